// File: doc/BRIEF.md
# Sparse Negacyclic Challenge Multiplier

This block multiplies a secret polynomial with small signed coefficients by a sparse binary challenge polynomial. The product lives in the ring of integer polynomials reduced modulo x^512 + 1. The challenge has exactly 23 coefficients equal to one and arrives as a list of 23 positions. So each product coefficient is a signed sum of 23 secret coefficients. A secret term whose index wraps past zero changes sign. No full polynomial multiplication is needed.

The secret polynomial sits in a memory next to the block. Each accumulator lane has its own read port into it, with one cycle of read latency. The lanes run in parallel, and each lane owns one contiguous block of output indices. For every output coefficient, a lane spends one cycle per challenge position. It then writes the finished coefficient through its own write port into the output memory. A one-cycle start pulse captures the challenge positions and launches the operation. A one-cycle done pulse marks the end. No modular reduction is applied to the results.

Top module: `spm_mult`

## Requirements
- R1: After reset, busy, done and every out_we bit are low.
- R2: Output coefficient i equals the sum over every challenge position p of s[(i - p) mod 512]. The term enters negated when i < p.
- R3: Accumulation never overflows. An all-minimum secret (every coefficient -4) gives exact results of magnitude up to 23 x 4 = 92.
- R4: During one operation, every output index 0..511 is written exactly once. Lane L writes only indices L*64 to L*64+63 (8 lanes), on its own slice of out_we, out_addr and out_data.
- R5: busy is high from the cycle after start is accepted until done rises. done is high for exactly one cycle. That cycle comes right after the cycle that carries the final writes, and busy is low in it.
- R6: A start pulse that arrives while busy is ignored. The results still follow the first challenge, and only one done pulse appears.
- R7: done rises 64 x 23 + 1 = 1473 clock edges after the edge that accepts start.
- R8: Challenge positions are captured at the accepting edge. Changing c_pos afterwards has no effect on the result. Position k sits in c_pos bits [9k+8:9k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; accepted only when idle |
| c_pos | input | 207 | 23 challenge positions, 9 bits each, position k in bits [9k+8:9k] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| s_rd_addr | output | 72 | Secret read address per lane, lane L in bits [9L+8:9L] |
| s_rd_data | input | 24 | Secret read data per lane (3-bit signed), valid one cycle after the address |
| out_we | output | 8 | Output write enable per lane |
| out_addr | output | 72 | Output write index per lane, lane L in bits [9L+8:9L] |
| out_data | output | 64 | Output coefficient per lane (8-bit signed), lane L in bits [8L+7:8L] |

## Verification
Some properties are checked by assertions on every cycle. These are: the accumulator sum stays inside the +/-92 bound, each lane's write index stays inside its own block, writes happen only while busy, done lasts a single cycle, and captured positions stay frozen while a start arrives during an operation. Other properties can only be shown by the bench's scenarios. These are: the negacyclic sign on wraparound, write coverage of exactly once per index, the exact start-to-done latency, and immunity to late changes on c_pos. The bench compares the written coefficients against a reference sum computed independently.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int LOG_N = 9;
    localparam int N     = 1 << LOG_N;
    localparam int KAPPA = 23;
    localparam int KW    = $clog2(KAPPA);
    localparam int SW    = 3;
    localparam int AW    = SW + $clog2(KAPPA + 1);
    localparam int BOUND = KAPPA * (1 << (SW - 1));

    typedef logic [LOG_N-1:0]        idx_t;
    typedef logic signed [SW-1:0]    coef_t;
    typedef logic signed [AW-1:0]    acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN
    } state_e;

    // One issue slot shared by all lanes
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
        idx_t offset;
        idx_t pos;
    } issue_t;

    // Source index for target t and challenge position p, modulo N
    function automatic idx_t src_index(idx_t t, idx_t p);
        return t - p;
    endfunction

    // Term wraps past zero and changes sign
    function automatic logic wraps(idx_t t, idx_t p);
        return t < p;
    endfunction
endpackage

// File: rtl/spm_sched.sv
module spm_sched
    import spm_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [KAPPA*LOG_N-1:0]    c_pos,
    output issue_t                    iss,
    output logic                      busy,
    output logic                      done
);
    localparam int BLK = N / LANES;

    state_e                        state_q;
    logic [KAPPA-1:0][LOG_N-1:0]   pos_q;
    logic [KW-1:0]                 k_q;
    idx_t                          j_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            j_q     <= '0;
            done    <= 1'b0;
            pos_q   <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pos_q   <= c_pos;
                        k_q     <= '0;
                        j_q     <= '0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (k_q == KW'(KAPPA - 1)) begin
                        k_q <= '0;
                        if (j_q == idx_t'(BLK - 1)) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            j_q <= j_q + 1'b1;
                        end
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        iss.valid  = (state_q == ST_ISSUE);
        iss.first  = (k_q == '0);
        iss.last   = (k_q == KW'(KAPPA - 1));
        iss.offset = j_q;
        iss.pos    = pos_q[k_q];
    end

    assign busy = (state_q != ST_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_q == ST_IDLE)); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(pos_q)); // R6
endmodule

// File: rtl/spm_lane.sv
module spm_lane
    import spm_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int LANE_ID = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  issue_t  iss,
    output idx_t    rd_addr,
    input  coef_t   rd_data,
    output logic    we,
    output idx_t    wr_addr,
    output acc_t    wr_data
);
    localparam int BLK  = N / LANES;
    localparam int BASE = LANE_ID * BLK;

    idx_t tgt;
    logic v1, first1, last1, neg1;
    idx_t tgt1;
    acc_t acc_q, ext, term, sum_c;

    assign tgt     = idx_t'(BASE) + iss.offset;
    assign rd_addr = src_index(tgt, iss.pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            v1     <= 1'b0;
            first1 <= 1'b0;
            last1  <= 1'b0;
            neg1   <= 1'b0;
            tgt1   <= '0;
            acc_q  <= '0;
        end else begin
            v1     <= iss.valid;
            first1 <= iss.first;
            last1  <= iss.last;
            neg1   <= wraps(tgt, iss.pos);
            tgt1   <= tgt;
            if (v1) begin
                acc_q <= sum_c;
            end
        end
    end

    always_comb begin
        ext   = acc_t'(rd_data);
        term  = neg1 ? -ext : ext;
        sum_c = (first1 ? acc_t'(0) : acc_q) + term;
    end

    assign we      = v1 && last1;
    assign wr_addr = tgt1;
    assign wr_data = sum_c;

    // Wide shadow sum, used only by the overflow check
    localparam logic signed [AW:0] LIM_P = (AW+1)'(BOUND);
    localparam logic signed [AW:0] LIM_N = -LIM_P;
    logic signed [AW:0] wide_c;
    assign wide_c = (first1 ? (AW+1)'(0) : {acc_q[AW-1], acc_q}) + {term[AW-1], term};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        v1 |-> ((wide_c <= LIM_P) && (wide_c >= LIM_N))); // R3
    AST_LANE_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> ((int'(wr_addr) >= BASE) && (int'(wr_addr) < BASE + BLK))); // R4
endmodule

// File: rtl/spm_mult.sv
module spm_mult
    import spm_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [KAPPA*LOG_N-1:0]    c_pos,
    output logic                      busy,
    output logic                      done,
    output logic [LANES*LOG_N-1:0]    s_rd_addr,
    input  logic [LANES*SW-1:0]       s_rd_data,
    output logic [LANES-1:0]          out_we,
    output logic [LANES*LOG_N-1:0]    out_addr,
    output logic [LANES*AW-1:0]       out_data
);
    issue_t iss;

    spm_sched #(.LANES(LANES)) sched_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .c_pos (c_pos),
        .iss   (iss),
        .busy  (busy),
        .done  (done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        idx_t  ra, wa;
        acc_t  wd;
        logic  w;

        spm_lane #(.LANES(LANES), .LANE_ID(l)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .iss     (iss),
            .rd_addr (ra),
            .rd_data (coef_t'(s_rd_data[l*SW +: SW])),
            .we      (w),
            .wr_addr (wa),
            .wr_data (wd)
        );

        assign s_rd_addr[l*LOG_N +: LOG_N] = ra;
        assign out_addr[l*LOG_N +: LOG_N]  = wa;
        assign out_data[l*AW +: AW]        = wd;
        assign out_we[l]                   = w;
    end

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|out_we) |-> busy); // R5
endmodule

// File: tb/spm_mult_tb.sv
`timescale 1ns/1ps
module spm_mult_tb_top;
    import spm_pkg::*;

    localparam int LANES = 8;
    localparam int BLK   = N / LANES;
    localparam int LAT   = BLK * KAPPA + 1;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      start = 1'b0;
    logic [KAPPA*LOG_N-1:0]    c_pos = '0;
    logic                      busy, done;
    logic [LANES*LOG_N-1:0]    s_rd_addr;
    logic [LANES*SW-1:0]       s_rd_data = '0;
    logic [LANES-1:0]          out_we;
    logic [LANES*LOG_N-1:0]    out_addr;
    logic [LANES*AW-1:0]       out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    coef_t s_mem   [N];
    acc_t  out_mem [N];
    int    wr_cnt  [N];
    int    bad_lane = 0;
    int    pos_arr [KAPPA];

    always #2 clk = ~clk;

    spm_mult #(.LANES(LANES)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .c_pos     (c_pos),
        .busy      (busy),
        .done      (done),
        .s_rd_addr (s_rd_addr),
        .s_rd_data (s_rd_data),
        .out_we    (out_we),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );

    // Secret memory: one registered read port per lane
    always @(posedge clk) begin
        for (int l = 0; l < LANES; l++)
            s_rd_data[l*SW +: SW] <= s_mem[s_rd_addr[l*LOG_N +: LOG_N]];
    end

    // Output memory with write bookkeeping
    always @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (out_we[l]) begin
                int a;
                a = int'(out_addr[l*LOG_N +: LOG_N]);
                out_mem[a] <= acc_t'(out_data[l*AW +: AW]);
                wr_cnt[a]  <= wr_cnt[a] + 1;
                if (a < l*BLK || a >= (l+1)*BLK) bad_lane <= bad_lane + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_coef(int i);
        int sum = 0;
        for (int k = 0; k < KAPPA; k++) begin
            int d = i - pos_arr[k];
            if (d < 0) sum -= int'(s_mem[d + N]);
            else       sum += int'(s_mem[d]);
        end
        return sum;
    endfunction

    // Runs one operation; optionally injects a start while busy and scrambles c_pos
    task automatic run_op(input int inject_at, input bit scramble, input string tag);
        int lat = 0;
        bit prev_we = 0;
        bit busy_gap = 0;
        int extra_done = 0;
        @(negedge clk);
        for (int i = 0; i < N; i++) wr_cnt[i] = 0;
        bad_lane = 0;
        for (int k = 0; k < KAPPA; k++) c_pos[k*LOG_N +: LOG_N] = idx_t'(pos_arr[k]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) c_pos = {KAPPA{idx_t'(9'h155)}};
        check(busy == 1'b1, "R5 busy after start", int'(busy), 1);
        while (lat < 4 * LAT) begin
            @(negedge clk);
            lat++;
            start = (lat == inject_at);
            if (inject_at > 0 && lat == inject_at)
                c_pos = {KAPPA{idx_t'(9'h0AA)}};
            if (done) break;
            if (!busy) busy_gap = 1;
            prev_we = |out_we;
        end
        start = 1'b0;
        check(lat == LAT, {"R7 latency ", tag}, lat, LAT);
        check(prev_we && out_we == '0, {"R5 done follows final write ", tag}, int'(prev_we), 1);
        check(!busy && !busy_gap, {"R5 busy window ", tag}, int'(busy_gap), 0);
        @(negedge clk);
        check(!done, {"R5 done single cycle ", tag}, int'(done), 0);
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (done) extra_done++;
        end
        check(extra_done == 0, {"R6 no extra done ", tag}, extra_done, 0);
        check(bad_lane == 0, {"R4 lane range ", tag}, bad_lane, 0);
        for (int i = 0; i < N; i++) begin
            check(wr_cnt[i] == 1, {"R4 write once ", tag}, wr_cnt[i], 1);
            check(int'(out_mem[i]) == ref_coef(i), {"R2 coefficient ", tag},
                  int'(out_mem[i]), ref_coef(i));
        end
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(out_we == '0, "R1 out_we", int'(out_we), 0);
    endtask

    task automatic t_sparse_random();
        for (int i = 0; i < N; i++) begin
            int r = $urandom_range(0, 99);
            s_mem[i] = (r < 15) ? coef_t'(1) : (r < 30) ? coef_t'(-1) : coef_t'(0);
        end
        for (int k = 0; k < KAPPA; k++) pos_arr[k] = (k * 37 + 5) % N;
        run_op(0, 0, "sparse");
    endtask

    task automatic t_wrap_full_range();
        for (int i = 0; i < N; i++) s_mem[i] = coef_t'(((i * 7) % 8) - 4);
        for (int k = 0; k < KAPPA; k++) pos_arr[k] = N - 1 - k * 22;
        pos_arr[KAPPA-1] = 0;
        run_op(0, 0, "wrap");
    endtask

    task automatic t_extreme();
        for (int i = 0; i < N; i++) s_mem[i] = coef_t'(-4);
        for (int k = 0; k < KAPPA; k++) pos_arr[k] = k;
        run_op(0, 0, "extreme R3");
        check(int'(out_mem[N-1]) == -92, "R3 most negative", int'(out_mem[N-1]), -92);
        check(int'(out_mem[0]) == 84, "R3 wrapped sum", int'(out_mem[0]), 84);
        for (int k = 0; k < KAPPA; k++) pos_arr[k] = N - 1 - k;
        run_op(0, 0, "extreme positive R3");
        check(int'(out_mem[0]) == 92, "R3 most positive", int'(out_mem[0]), 92);
    endtask

    task automatic t_busy_start();
        for (int i = 0; i < N; i++) s_mem[i] = coef_t'((i % 3) - 1);
        for (int k = 0; k < KAPPA; k++) pos_arr[k] = (k * 101 + 17) % N;
        run_op(300, 1, "R6 R8 late start and c_pos change");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            s_mem[i] = '0;
            out_mem[i] = '0;
            wr_cnt[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sparse_random();
        t_wrap_full_range();
        t_extreme();
        t_busy_start();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule